// File: doc/BRIEF.md
# NAND Flash Channel Controller

This block drives a single NAND flash device over an 8-bit shared I/O bus. A host-side agent hands it one request at a time: a 2-bit operation code, a 24-bit row (page/block) address and a 16-bit column address. Every command byte, address byte and data byte goes over the same bus. The controller frames each byte with the command-latch or address-latch qualifier and a write-enable or read-enable strobe. Page data for a program arrives on a valid/ready byte stream. Page data from a read leaves on a valid-qualified byte stream with no back-pressure.

A main state machine holds the request in its command and address registers and hands it to an operation sequencer. The main machine has the states MAIN_IDLE, MAIN_READ, MAIN_PROG and MAIN_ERASE. It moves from MAIN_IDLE to an operation state when it accepts a non-idle code. It returns to MAIN_IDLE on the sequencer's done strobe.

The sequencer walks the following states:
- SQ_IDLE
- SQ_CMD1: opening command
- SQ_ADDR: address bytes
- SQ_WDATA: program data
- SQ_CMD2: confirm command
- SQ_TWB: fixed settle delay
- SQ_RB: wait for ready
- SQ_STCMD: status command
- SQ_STRD: status read
- SQ_RDATA: page read-out
- SQ_FIN: completion

Each sequencer bus state hands one byte to a strobe engine. The engine's states are BE_IDLE, BE_LOW and BE_HIGH. It shapes the low and high phases of the strobe.

Top module: `nand_chan_ctrl`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle and nand_ale are low, req_ready is high and done is low.
- R2: A request with op code 00 has no effect: no strobe pulses, no done, chip enable stays high and req_ready stays high.
- R3: From the cycle after a non-idle request is accepted until done, req_ready is low, and requests offered meanwhile are ignored and cause no bus activity.
- R4: Op code 01 (page read) writes, in order: command 00h, column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, row bits 23:16, command 30h. Command bytes carry nand_cle high and address bytes carry nand_ale high.
- R5: After the last command of an operation, the controller waits T_WB cycles and then until nand_rb is high. No read-enable pulse occurs while nand_rb is low.
- R6: A page read returns PAGE_BYTES bytes on rd_data. Each byte is qualified by a one-cycle rd_valid pulse, and the bytes come in the order the device presents them.
- R7: Op code 10 (program) writes command 80h, the five address bytes as in R4, PAGE_BYTES data bytes taken in stream order from wr_data (neither latch qualifier high), command 10h, and after ready, status command 70h followed by one status read.
- R8: Op code 11 (erase) writes command 60h, the three row bytes low to high, command D0h, and after ready, status command 70h followed by one status read.
- R9: For program and erase, fail equals bit 0 of the status byte. For a read, fail is 0.
- R10: done is a one-cycle pulse with fail valid in the same cycle. At done, chip enable is high and req_ready is high again.
- R11: Every write-enable and read-enable low pulse lasts exactly T_LO cycles. nand_cle, nand_ale and nand_dq_out stay stable and nand_dq_oe stays high during a write-enable low pulse.
- R12: nand_cle and nand_ale are never high together, and nand_we_n and nand_re_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 00 idle, 01 read page, 10 program page, 11 erase block |
| req_row | input | ROW_W | Page/block row address |
| req_col | input | COL_W | Column address |
| wr_valid | input | 1 | Program data byte available |
| wr_ready | output | 1 | Program data byte taken this cycle when wr_valid is high |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read data byte valid (one cycle) |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | Operation complete pulse |
| fail | output | 1 | Status result, valid with done |
| nand_ce_n | output | 1 | Device chip enable, active low |
| nand_cle | output | 1 | Command latch qualifier |
| nand_ale | output | 1 | Address latch qualifier |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven to the device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus byte from the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
A sequencer stuck in or skipping a state shows at the device pins within one strobe period. The byte log then holds a wrong byte, a missing byte or a wrong latch qualifier, or the operation hangs and done never comes. A wrong byte counter appears as a page that is one byte short or long in the write log or on rd_valid. A wrong status path shows as a fail value that disagrees with the device's status bit at done. An engine counter error shows on the very first strobe as a low pulse of the wrong length. The sweep covers every op code against edge-valued addresses and both status outcomes, so each of these faults surfaces within one operation.

// File: rtl/nand_chan_pkg.sv
package nand_chan_pkg;
    localparam int IO_W = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_PROG  = 2'b10,
        OP_ERASE = 2'b11
    } nand_op_e;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_DOUT = 2'd2,
        K_DIN  = 2'd3
    } bus_kind_e;

    localparam logic [IO_W-1:0] CMD_RD_OPEN  = 8'h00;
    localparam logic [IO_W-1:0] CMD_RD_GO    = 8'h30;
    localparam logic [IO_W-1:0] CMD_PG_OPEN  = 8'h80;
    localparam logic [IO_W-1:0] CMD_PG_GO    = 8'h10;
    localparam logic [IO_W-1:0] CMD_ER_OPEN  = 8'h60;
    localparam logic [IO_W-1:0] CMD_ER_GO    = 8'hD0;
    localparam logic [IO_W-1:0] CMD_STATUS   = 8'h70;
endpackage

// File: rtl/nand_bus_engine.sv
module nand_bus_engine
    import nand_chan_pkg::*;
#(
    parameter int T_LO = 2,
    parameter int T_HI = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  bus_kind_e       kind,
    input  logic [IO_W-1:0] wbyte,
    input  logic [IO_W-1:0] dq_in,
    output logic            done,
    output logic [IO_W-1:0] rbyte,
    output logic            cle,
    output logic            ale,
    output logic            we_n,
    output logic            re_n,
    output logic [IO_W-1:0] dq_out,
    output logic            dq_oe
);
    localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LO_LAST = CW'(T_LO - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(T_HI - 1);

    typedef enum logic [1:0] {BE_IDLE, BE_LOW, BE_HIGH} eng_st_e;

    eng_st_e         st, st_nx;
    logic [CW-1:0]   cnt;
    bus_kind_e       kind_q;
    logic [IO_W-1:0] byte_q;
    logic [IO_W-1:0] rbyte_q;
    logic            active, wr_kind;

    always_comb begin
        st_nx = st;
        unique case (st)
            BE_IDLE: if (start)          st_nx = BE_LOW;
            BE_LOW:  if (cnt == LO_LAST) st_nx = BE_HIGH;
            BE_HIGH: if (cnt == HI_LAST) st_nx = BE_IDLE;
            default:                     st_nx = BE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= BE_IDLE;
            cnt     <= '0;
            kind_q  <= K_CMD;
            byte_q  <= '0;
            rbyte_q <= '0;
        end else begin
            st <= st_nx;
            if (st_nx != st) cnt <= '0;
            else             cnt <= cnt + 1'b1;
            if (start && st == BE_IDLE) begin
                kind_q <= kind;
                byte_q <= wbyte;
            end
            if (st == BE_LOW && cnt == LO_LAST && kind_q == K_DIN)
                rbyte_q <= dq_in;
        end
    end

    always_comb begin
        active  = (st != BE_IDLE);
        wr_kind = (kind_q != K_DIN);
        done    = (st == BE_HIGH) && (cnt == HI_LAST);
        cle     = active && (kind_q == K_CMD);
        ale     = active && (kind_q == K_ADDR);
        we_n    = !((st == BE_LOW) && wr_kind);
        re_n    = !((st == BE_LOW) && !wr_kind);
        dq_oe   = active && wr_kind;
        dq_out  = dq_oe ? byte_q : '0;
        rbyte   = rbyte_q;
    end

    // R11: a byte is only handed over while the engine is free
    assert_start_when_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st == BE_IDLE));
    // R11: the low phase always ends in a high phase, never straight to idle
    assert_low_then_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BE_LOW && cnt == LO_LAST) |=> (st == BE_HIGH));
    // R11: bus byte held across a low write strobe
    assert_dq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(dq_out));
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_chan_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int T_WB       = 4,
    parameter int COL_W      = 16,
    parameter int ROW_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  nand_op_e         op,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             wr_valid,
    input  logic [IO_W-1:0]  wr_data,
    output logic             wr_ready,
    output logic             rd_valid,
    output logic [IO_W-1:0]  rd_data,
    input  logic             rb,
    output logic             eng_start,
    output bus_kind_e        eng_kind,
    output logic [IO_W-1:0]  eng_wbyte,
    input  logic             eng_done,
    input  logic [IO_W-1:0]  eng_rbyte,
    output logic             seq_done,
    output logic             seq_fail
);
    localparam int COL_BYTES  = COL_W / IO_W;
    localparam int ADDR_BYTES = (COL_W + ROW_W) / IO_W;
    localparam int IMAX       = (PAGE_BYTES > ADDR_BYTES) ? PAGE_BYTES : ADDR_BYTES;
    localparam int IW         = $clog2(IMAX + 1);
    localparam int WBW        = $clog2(T_WB + 1);
    localparam logic [IW-1:0]  ADDR_LAST = IW'(ADDR_BYTES - 1);
    localparam logic [IW-1:0]  ADDR_ROW0 = IW'(COL_BYTES);
    localparam logic [IW-1:0]  PAGE_LAST = IW'(PAGE_BYTES - 1);
    localparam logic [WBW-1:0] WB_LAST   = WBW'(T_WB - 1);

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_CMD1, SQ_ADDR, SQ_WDATA, SQ_CMD2, SQ_TWB,
        SQ_RB, SQ_STCMD, SQ_STRD, SQ_RDATA, SQ_FIN
    } seq_st_e;

    seq_st_e                 st, st_nx;
    logic                    pend;
    logic [IW-1:0]           idx;
    logic [WBW-1:0]          wb_cnt;
    logic                    fail_q;
    logic [COL_W+ROW_W-1:0]  addr_all;
    logic [IO_W-1:0]         addr_byte, open_cmd, go_cmd;

    always_comb begin
        addr_all  = {row, col};
        addr_byte = addr_all[int'(idx)*IO_W +: IO_W];
        unique case (op)
            OP_PROG:  begin open_cmd = CMD_PG_OPEN; go_cmd = CMD_PG_GO; end
            OP_ERASE: begin open_cmd = CMD_ER_OPEN; go_cmd = CMD_ER_GO; end
            default:  begin open_cmd = CMD_RD_OPEN; go_cmd = CMD_RD_GO; end
        endcase
    end

    // next-state process
    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE:  if (start) st_nx = SQ_CMD1;
            SQ_CMD1:  if (eng_done) st_nx = SQ_ADDR;
            SQ_ADDR:  if (eng_done && idx == ADDR_LAST)
                          st_nx = (op == OP_PROG) ? SQ_WDATA : SQ_CMD2;
            SQ_WDATA: if (eng_done && idx == PAGE_LAST) st_nx = SQ_CMD2;
            SQ_CMD2:  if (eng_done) st_nx = SQ_TWB;
            SQ_TWB:   if (wb_cnt == WB_LAST) st_nx = SQ_RB;
            SQ_RB:    if (rb) st_nx = (op == OP_READ) ? SQ_RDATA : SQ_STCMD;
            SQ_STCMD: if (eng_done) st_nx = SQ_STRD;
            SQ_STRD:  if (eng_done) st_nx = SQ_FIN;
            SQ_RDATA: if (eng_done && idx == PAGE_LAST) st_nx = SQ_FIN;
            SQ_FIN:   st_nx = SQ_IDLE;
            default:  st_nx = SQ_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            pend   <= 1'b0;
            idx    <= '0;
            wb_cnt <= '0;
            fail_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (eng_done)       pend <= 1'b0;
            else if (eng_start) pend <= 1'b1;
            if (st_nx != st)
                idx <= (st_nx == SQ_ADDR && op == OP_ERASE) ? ADDR_ROW0 : '0;
            else if (eng_done)
                idx <= idx + 1'b1;
            if (st != SQ_TWB) wb_cnt <= '0;
            else              wb_cnt <= wb_cnt + 1'b1;
            if (st == SQ_IDLE && start)     fail_q <= 1'b0;
            if (st == SQ_STRD && eng_done)  fail_q <= eng_rbyte[0];
        end
    end

    // output process
    always_comb begin
        eng_start = 1'b0;
        eng_kind  = K_CMD;
        eng_wbyte = '0;
        wr_ready  = 1'b0;
        unique case (st)
            SQ_CMD1:  begin eng_start = !pend; eng_wbyte = open_cmd; end
            SQ_ADDR:  begin eng_start = !pend; eng_kind = K_ADDR; eng_wbyte = addr_byte; end
            SQ_WDATA: begin
                wr_ready  = !pend;
                eng_start = !pend && wr_valid;
                eng_kind  = K_DOUT;
                eng_wbyte = wr_data;
            end
            SQ_CMD2:  begin eng_start = !pend; eng_wbyte = go_cmd; end
            SQ_STCMD: begin eng_start = !pend; eng_wbyte = CMD_STATUS; end
            SQ_STRD,
            SQ_RDATA: begin eng_start = !pend; eng_kind = K_DIN; end
            default: ;
        endcase
        rd_valid = (st == SQ_RDATA) && eng_done;
        rd_data  = eng_rbyte;
        seq_done = (st == SQ_FIN);
        seq_fail = fail_q;
    end

    // R5: nothing is read from the device unless it reports ready
    assert_read_only_when_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_kind == K_DIN) |-> rb);
    // R7: each data byte taken closes the window until the engine is done with it
    assert_one_byte_per_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && wr_valid) |=> !wr_ready);
endmodule

// File: rtl/nand_chan_ctrl.sv
module nand_chan_ctrl
    import nand_chan_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int T_LO       = 2,
    parameter int T_HI       = 1,
    parameter int T_WB       = 4,
    parameter int COL_W      = 16,
    parameter int ROW_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             fail,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb
);
    typedef enum logic [1:0] {MAIN_IDLE, MAIN_READ, MAIN_PROG, MAIN_ERASE} main_st_e;

    main_st_e         m_st, m_nx;
    nand_op_e         op_in, op_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             accept, done_q, fail_q, rb_q;
    logic             seq_done, seq_fail, eng_start, eng_done;
    bus_kind_e        eng_kind;
    logic [IO_W-1:0]  eng_wbyte, eng_rbyte;

    assign op_in  = nand_op_e'(req_op);
    assign accept = (m_st == MAIN_IDLE) && req_valid && (op_in != OP_IDLE);

    always_comb begin
        m_nx = m_st;
        unique case (m_st)
            MAIN_IDLE: if (accept) begin
                unique case (op_in)
                    OP_READ:  m_nx = MAIN_READ;
                    OP_PROG:  m_nx = MAIN_PROG;
                    OP_ERASE: m_nx = MAIN_ERASE;
                    default:  m_nx = MAIN_IDLE;
                endcase
            end
            MAIN_READ, MAIN_PROG, MAIN_ERASE: if (seq_done) m_nx = MAIN_IDLE;
            default: m_nx = MAIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st   <= MAIN_IDLE;
            op_q   <= OP_IDLE;
            row_q  <= '0;
            col_q  <= '0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            rb_q   <= 1'b0;
        end else begin
            m_st   <= m_nx;
            rb_q   <= nand_rb;
            done_q <= (m_st != MAIN_IDLE) && seq_done;
            if (accept) begin
                op_q  <= op_in;
                row_q <= req_row;
                col_q <= req_col;
            end
            if (m_st != MAIN_IDLE && seq_done) fail_q <= seq_fail;
        end
    end

    always_comb begin
        req_ready = (m_st == MAIN_IDLE);
        nand_ce_n = (m_st == MAIN_IDLE);
        done      = done_q;
        fail      = fail_q;
    end

    nand_op_seq #(
        .PAGE_BYTES(PAGE_BYTES), .T_WB(T_WB), .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .op(op_q),
        .row(row_q), .col(col_q),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rb(rb_q),
        .eng_start(eng_start), .eng_kind(eng_kind), .eng_wbyte(eng_wbyte),
        .eng_done(eng_done), .eng_rbyte(eng_rbyte),
        .seq_done(seq_done), .seq_fail(seq_fail)
    );

    nand_bus_engine #(.T_LO(T_LO), .T_HI(T_HI)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .kind(eng_kind),
        .wbyte(eng_wbyte), .dq_in(nand_dq_in), .done(eng_done), .rbyte(eng_rbyte),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_out(nand_dq_out), .dq_oe(nand_dq_oe)
    );

    assert_busy_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op != 2'b00) |=> !req_ready);
    assert_idle_code_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n |-> (nand_we_n && nand_re_n));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_back_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && nand_ce_n));
    assert_latch_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    assert_strobe_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    assert_read_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_READ) |-> !fail);
endmodule

// File: tb/nand_chan_ctrl_bench.sv
`timescale 1ns/1ps
module nand_chan_ctrl_bench;
    localparam int PAGE = 8;
    localparam int TLO  = 2;
    localparam int THI  = 1;
    localparam int TWB  = 4;
    localparam int BUSY = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [23:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic        wr_valid = 1'b1, wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid, done, fail;
    logic [7:0]  rd_data;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rb = 1'b1;

    nand_chan_ctrl #(.PAGE_BYTES(PAGE), .T_LO(TLO), .T_HI(THI), .T_WB(TWB)) u_nand_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_row(req_row), .req_col(req_col),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .fail(fail),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rpat(input logic [23:0] r, input int i);
        return r[7:0] ^ 8'(i * 5 + 3);
    endfunction
    function automatic logic [7:0] wpat(input logic [23:0] r, input int i);
        return 8'(int'(r[15:8]) + i * 7 + 1);
    endfunction

    // device model and monitors, all sampled on the falling edge
    int        log_n = 0;
    int        log_k [0:63];
    logic [7:0] log_b [0:63];
    int        rd_n = 0;
    logic [7:0] rd_buf [0:63];
    logic      stat_fail = 1'b0, smode = 1'b0;
    logic [23:0] cur_row = '0;
    int        ridx = 0, busy_cnt = 0, wr_idx = 0;
    logic      wr_take = 1'b0;
    int        done_cnt = 0;
    logic      last_fail = 1'b0;
    int        we_run = 0, re_run = 0;
    int        w_viol = 0, s_viol = 0, x_viol = 0, rb_viol = 0, dw_viol = 0;
    logic      p_we = 1'b1, p_re = 1'b1, p_cle = 1'b0, p_ale = 1'b0, p_done = 1'b0;
    logic [7:0] p_dq = '0;

    assign nand_dq_in = smode ? {7'b0, stat_fail} : rpat(cur_row, ridx);

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_we == 1'b0 && nand_we_n == 1'b1 && !nand_ce_n && log_n < 64) begin
                log_k[log_n] = nand_cle ? 0 : (nand_ale ? 1 : 2);
                log_b[log_n] = nand_dq_out;
                log_n++;
                if (nand_cle && (nand_dq_out == 8'h30 || nand_dq_out == 8'h10 ||
                                 nand_dq_out == 8'hD0)) begin
                    nand_rb  = 1'b0;
                    busy_cnt = BUSY;
                end
                if (nand_cle && nand_dq_out == 8'h70) smode = 1'b1;
                if (nand_cle && nand_dq_out == 8'h30) begin smode = 1'b0; ridx = 0; end
            end else if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) nand_rb = 1'b1;
            end
            if (p_re == 1'b0 && nand_re_n == 1'b1) ridx++;
            if (rd_valid && rd_n < 64) begin rd_buf[rd_n] = rd_data; rd_n++; end
            if (done) begin done_cnt++; last_fail = fail; end
            if (done && p_done) dw_viol++;
            // R11 strobe widths and hold
            if (!nand_we_n) we_run++;
            else begin if (we_run != 0 && we_run != TLO) w_viol++; we_run = 0; end
            if (!nand_re_n) re_run++;
            else begin if (re_run != 0 && re_run != TLO) w_viol++; re_run = 0; end
            if (!nand_we_n && !p_we && (nand_dq_out != p_dq || nand_cle != p_cle ||
                                        nand_ale != p_ale)) s_viol++;
            if (!nand_we_n && !nand_dq_oe) s_viol++;
            // R12 exclusivity, R5 no read while busy
            if (nand_cle && nand_ale) x_viol++;
            if (!nand_we_n && !nand_re_n) x_viol++;
            if (!nand_rb && !nand_re_n) rb_viol++;
            // program data stream
            if (wr_take) wr_idx++;
            wr_data = wpat(cur_row, wr_idx);
            wr_take = wr_ready && wr_valid;
        end
        p_we = nand_we_n; p_re = nand_re_n; p_cle = nand_cle; p_ale = nand_ale;
        p_dq = nand_dq_out; p_done = done;
    end

    // expected write log
    int        exp_n;
    int        exp_k [0:63];
    logic [7:0] exp_b [0:63];
    task automatic push(input int k, input logic [7:0] b);
        exp_k[exp_n] = k; exp_b[exp_n] = b; exp_n++;
    endtask

    task automatic build_exp(input logic [1:0] op, input logic [23:0] row, input logic [15:0] col);
        logic [39:0] a;
        a = {row, col};
        exp_n = 0;
        if (op == 2'b01) begin
            push(0, 8'h00);
            for (int i = 0; i < 5; i++) push(1, a[i*8 +: 8]);
            push(0, 8'h30);
        end else if (op == 2'b10) begin
            push(0, 8'h80);
            for (int i = 0; i < 5; i++) push(1, a[i*8 +: 8]);
            for (int i = 0; i < PAGE; i++) push(2, wpat(row, i));
            push(0, 8'h10);
            push(0, 8'h70);
        end else if (op == 2'b11) begin
            push(0, 8'h60);
            for (int i = 2; i < 5; i++) push(1, a[i*8 +: 8]);
            push(0, 8'hD0);
            push(0, 8'h70);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [23:0] row,
                         input logic [15:0] col, input logic sf);
        int d0, bad;
        string tg;
        @(negedge clk);
        log_n = 0; rd_n = 0; stat_fail = sf; cur_row = row; wr_idx = 0;
        w_viol = 0; s_viol = 0; x_viol = 0; rb_viol = 0; dw_viol = 0;
        d0 = done_cnt;
        req_valid = 1'b1; req_op = op; req_row = row; req_col = col;
        @(negedge clk);
        req_valid = 1'b0;
        if (op == 2'b00) begin
            repeat (20) @(negedge clk);
            check(log_n == 0, "R2 no bus bytes for idle code", log_n, 0);
            check(done_cnt == d0, "R2 no done for idle code", done_cnt - d0, 0);
            check(req_ready && nand_ce_n, "R2 ready and ce_n stay high", int'(req_ready), 1);
            return;
        end
        check(!req_ready, "R3 ready low after accept", int'(req_ready), 0);
        req_valid = 1'b1; req_op = 2'b11; req_row = ~row; req_col = ~col;
        repeat (3) @(negedge clk);
        check(!req_ready, "R3 ready low while busy", int'(req_ready), 0);
        req_valid = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        check(done_cnt == d0 + 1, "R10 exactly one done", done_cnt - d0, 1);
        check(dw_viol == 0, "R10 done one cycle wide", dw_viol, 0);
        check(req_ready && nand_ce_n, "R10 back to idle at done", int'(req_ready), 1);
        check(last_fail == ((op == 2'b01) ? 1'b0 : sf), "R9 fail value",
              int'(last_fail), (op == 2'b01) ? 0 : int'(sf));
        build_exp(op, row, col);
        tg = (op == 2'b01) ? "R4 read byte sequence" :
             (op == 2'b10) ? "R7 program byte sequence" : "R8 erase byte sequence";
        check(log_n == exp_n, {tg, " length (R3 extra requests ignored)"}, log_n, exp_n);
        bad = -1;
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (bad < 0 && (log_k[i] != exp_k[i] || log_b[i] != exp_b[i])) bad = i;
        if (bad >= 0)
            check(1'b0, tg, int'(log_b[bad]) + 256 * log_k[bad],
                  int'(exp_b[bad]) + 256 * exp_k[bad]);
        else
            check(1'b1, tg, 0, 0);
        if (op == 2'b01) begin
            check(rd_n == PAGE, "R6 read byte count", rd_n, PAGE);
            bad = -1;
            for (int i = 0; i < PAGE && i < rd_n; i++)
                if (bad < 0 && rd_buf[i] != rpat(row, i)) bad = i;
            if (bad >= 0) check(1'b0, "R6 read data", int'(rd_buf[bad]), int'(rpat(row, bad)));
            else          check(1'b1, "R6 read data", 0, 0);
        end else begin
            check(rd_n == 0, "R6 no read stream outside reads", rd_n, 0);
        end
        check(rb_viol == 0, "R5 no read pulse while busy", rb_viol, 0);
        check(w_viol == 0, "R11 strobe low width", w_viol, 0);
        check(s_viol == 0, "R11 qualifiers stable in strobe", s_viol, 0);
        check(x_viol == 0, "R12 exclusive qualifiers and strobes", x_viol, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    logic [23:0] rows [0:2];
    logic [15:0] cols [0:2];

    initial begin
        rows[0] = 24'h000001; rows[1] = 24'h5A3C96; rows[2] = 24'hFFFFFE;
        cols[0] = 16'h0000;   cols[1] = 16'hA55A;   cols[2] = 16'hFFFF;
        repeat (3) @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes high in reset", 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!nand_cle && !nand_ale, "R1 latch qualifiers low", int'(nand_cle), 0);
        check(req_ready && !done, "R1 ready high, done low", int'(req_ready), 1);
        check(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes high after reset", 0, 1);
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 3; a++)
                for (int f = 0; f < 2; f++)
                    do_op(2'(op), rows[a], cols[a], 1'(f));
        do_op(2'b01, 24'h123456, 16'h789A, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule